// File: doc/BRIEF.md
# GPIO Interrupt Routing Multiplexer

This block sits between three banks of GPIO interrupt requests, each 32 lines wide, and the platform interrupt controller. It drives 41 global interrupt lines. Outputs 0 to 37 are dedicated per-line connections. Outputs 38, 39 and 40 are per-bank aggregates. A 32-bit routing word decides, for each of the first 32 outputs, whether the output takes its default line from bank 0 or bank 1, or takes the same-numbered line of bank 2.

Each aggregate output is the OR of the lines in its bank that do not own a dedicated output in the current routing. As a result, every request reaches the controller through exactly one output. Bank 0 lines 14 to 31 and bank 1 lines 24 to 31 have no dedicated output, so they only ever appear on their bank's aggregate. A parameter selects whether the 41 outputs are registered or passed straight through. When registered, they use a synchronous active-high reset.

Top module: `gpio_irq_router`

## Requirements
- R1: With output registering enabled, a cycle with `rst` high clears all 41 bits of `gbl_irq` to 0 at the next clock edge.
- R2: For n in 0..13 with `route_cfg[n]`=0, `gbl_irq[n]` equals bank 0 line n.
- R3: For n in 14..31 with `route_cfg[n]`=0, `gbl_irq[n]` equals bank 1 line n-14.
- R4: `gbl_irq[37:32]` always equals bank 1 lines 23..18, whatever the routing word holds.
- R5: For n in 0..31 with `route_cfg[n]`=1, `gbl_irq[n]` equals bank 2 line n.
- R6: `gbl_irq[38]` is the OR of bank 0 lines 14..31 and of every bank 0 line n<14 whose `route_cfg[n]` is 1.
- R7: `gbl_irq[39]` is the OR of bank 1 lines 24..31 and of every bank 1 line k<18 whose `route_cfg[14+k]` is 1. Lines 18..23 never contribute.
- R8: `gbl_irq[40]` is the OR of every bank 2 line n whose `route_cfg[n]` is 0.
- R9: With registering enabled, `gbl_irq` reflects the inputs sampled at the previous rising clock edge. An input change between edges does not affect the outputs until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| bank0_irq | input | 32 | Interrupt requests of bank 0 |
| bank1_irq | input | 32 | Interrupt requests of bank 1 |
| bank2_irq | input | 32 | Interrupt requests of bank 2 |
| route_cfg | input | 32 | Routing word; bit n set gives output n to bank 2 line n |
| gbl_irq | output | 41 | Global interrupt lines to the controller |

## Verification
Dedicated routing and aggregate exclusion are decided in the same cycle by the same routing bit. When that bit flips, one request must move from a dedicated output to its bank aggregate, or back again. The bench provokes this in two ways: it walks a single active line through each bank while the routing bit for that line is set and then cleared, and it also applies random requests under all-zero, all-one and random routing words. In every case each output segment is compared against a model computed arithmetically in the bench, so a request that appears on two outputs or on none is caught.

// File: rtl/gir_pkg.sv
package gir_pkg;
  localparam int GIR_LINES = 32;
  localparam int GIR_B0_DIRECT = 14;
  localparam int GIR_B1_DIRECT = 24;
  localparam int GIR_BANKS = 3;
endpackage

// File: rtl/gir_direct_sel.sv
module gir_direct_sel #(
  parameter int LINES = 32,
  parameter int B0N = 14,
  parameter int B1N = 24,
  localparam int NDIR = B0N + B1N
) (
  input  logic [LINES-1:0] bank0_i,
  input  logic [LINES-1:0] bank1_i,
  input  logic [LINES-1:0] bank2_i,
  input  logic [LINES-1:0] cfg_i,
  output logic [NDIR-1:0]  direct_o
);
  for (genvar i = 0; i < NDIR; i++) begin : g_out
    logic base;
    if (i < B0N) begin : g_b0
      assign base = bank0_i[i];
    end else begin : g_b1
      localparam int K = i - B0N;
      assign base = bank1_i[K];
    end
    if (i < LINES) begin : g_swap
      assign direct_o[i] = cfg_i[i] ? bank2_i[i] : base;
    end else begin : g_fixed
      assign direct_o[i] = base;
    end
  end
endmodule

// File: rtl/gir_aggregate.sv
module gir_aggregate #(
  parameter int LINES = 32,
  parameter int B0N = 14,
  parameter int B1N = 24
) (
  input  logic [LINES-1:0] bank0_i,
  input  logic [LINES-1:0] bank1_i,
  input  logic [LINES-1:0] bank2_i,
  input  logic [LINES-1:0] cfg_i,
  output logic [2:0]       agg_o
);
  logic [LINES-1:0] own0, own1, own2;

  for (genvar n = 0; n < LINES; n++) begin : g_mask
    // bank 0: owns output n unless rerouted to bank 2
    if (n < B0N) begin : g_o0
      assign own0[n] = ~cfg_i[n];
    end else begin : g_n0
      assign own0[n] = 1'b0;
    end
    // bank 1: owns output B0N+n; swappable only below LINES
    if (n < B1N) begin : g_o1
      if (B0N + n < LINES) begin : g_sw
        localparam int P = B0N + n;
        assign own1[n] = ~cfg_i[P];
      end else begin : g_fx
        assign own1[n] = 1'b1;
      end
    end else begin : g_n1
      assign own1[n] = 1'b0;
    end
    // bank 2: owns output n only when selected
    if (n < B0N + B1N) begin : g_o2
      assign own2[n] = cfg_i[n];
    end else begin : g_n2
      assign own2[n] = 1'b0;
    end
  end

  assign agg_o[0] = |(bank0_i & ~own0);
  assign agg_o[1] = |(bank1_i & ~own1);
  assign agg_o[2] = |(bank2_i & ~own2);
endmodule

// File: rtl/gir_out_stage.sv
module gir_out_stage #(
  parameter int W = 41,
  parameter bit REGISTERED = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) q_o <= '0;
      else     q_o <= d_i;
    end
  end else begin : g_comb
    assign q_o = d_i;
  end
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gir_pkg::*;
#(
  parameter int LINES = GIR_LINES,
  parameter int B0N = GIR_B0_DIRECT,
  parameter int B1N = GIR_B1_DIRECT,
  parameter bit REGISTERED = 1'b1,
  localparam int NDIR = B0N + B1N,
  localparam int NOUT = NDIR + GIR_BANKS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LINES-1:0] bank0_irq,
  input  logic [LINES-1:0] bank1_irq,
  input  logic [LINES-1:0] bank2_irq,
  input  logic [LINES-1:0] route_cfg,
  output logic [NOUT-1:0]  gbl_irq
);
  logic [NDIR-1:0] direct;
  logic [2:0]      agg;

  gir_direct_sel #(.LINES(LINES), .B0N(B0N), .B1N(B1N)) u_dir (
    .bank0_i(bank0_irq), .bank1_i(bank1_irq), .bank2_i(bank2_irq),
    .cfg_i(route_cfg), .direct_o(direct)
  );

  gir_aggregate #(.LINES(LINES), .B0N(B0N), .B1N(B1N)) u_agg (
    .bank0_i(bank0_irq), .bank1_i(bank1_irq), .bank2_i(bank2_irq),
    .cfg_i(route_cfg), .agg_o(agg)
  );

  gir_out_stage #(.W(NOUT), .REGISTERED(REGISTERED)) u_out (
    .clk(clk), .rst(rst), .d_i({agg, direct}), .q_o(gbl_irq)
  );

  if (REGISTERED) begin : g_chk
    a_r1_reset_clear: assert property (@(posedge clk)
      rst |=> gbl_irq == '0);
    a_r2_bank0_line0: assert property (@(posedge clk) disable iff (rst)
      !route_cfg[0] |=> gbl_irq[0] == $past(bank0_irq[0]));
    a_r5_bank2_line0: assert property (@(posedge clk) disable iff (rst)
      route_cfg[0] |=> gbl_irq[0] == $past(bank2_irq[0]));
    a_r8_bank2_quiet: assert property (@(posedge clk) disable iff (rst)
      (bank2_irq == '0) |=> !gbl_irq[NDIR+2]);
    a_r6_bank0_quiet: assert property (@(posedge clk) disable iff (rst)
      (bank0_irq == '0) |=> !gbl_irq[NDIR]);
    if (NDIR > LINES) begin : g_fix
      a_r4_fixed_lines: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> gbl_irq[NDIR-1:LINES] == $past(bank1_irq[B1N-1:LINES-B0N]));
    end
  end
endmodule

// File: tb/gpio_irq_router_test.sv
module gpio_irq_router_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] b0 = '0, b1 = '0, b2 = '0, cfg = '0;
  logic [40:0] q;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_router uut (
    .clk(clk), .rst(rst), .bank0_irq(b0), .bank1_irq(b1),
    .bank2_irq(b2), .route_cfg(cfg), .gbl_irq(q)
  );

  function automatic logic [40:0] model(input logic [31:0] a0, a1, a2, c);
    logic [40:0] e;
    e = '0;
    for (int i = 0; i < 38; i++) begin
      if (i < 14) e[i] = a0[i]; else e[i] = a1[i-14];
      if (i < 32 && c[i]) e[i] = a2[i];
    end
    for (int n = 0; n < 32; n++) begin
      if (n >= 14 || c[n]) e[38] = e[38] | a0[n];
      if (n >= 24 || (n < 18 && c[14+n])) e[39] = e[39] | a1[n];
      if (!c[n]) e[40] = e[40] | a2[n];
    end
    return e;
  endfunction

  task automatic chk(input string req, input logic [40:0] exp, input logic [40:0] mask);
    checks++;
    if (((q ^ exp) & mask) != '0) begin
      fails++;
      $display("FAIL %s: got %h expected %h (mask %h)", req, q & mask, exp & mask, mask);
    end
  endtask

  task automatic apply(input logic [31:0] a0, a1, a2, c);
    logic [40:0] e, m;
    @(negedge clk);
    b0 = a0; b1 = a1; b2 = a2; cfg = c;
    @(posedge clk); #1;
    e = model(a0, a1, a2, c);
    m = '0;
    for (int i = 0; i < 14; i++) m[i] = ~c[i];
    chk("R2", e, m);
    m = '0;
    for (int i = 14; i < 32; i++) m[i] = ~c[i];
    chk("R3", e, m);
    chk("R4", e, 41'h3F << 32);
    chk("R5", e, {9'd0, c});
    chk("R6", e, 41'd1 << 38);
    chk("R7", e, 41'd1 << 39);
    chk("R8", e, 41'd1 << 40);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [40:0] held;
    b0 = '1; b1 = '1; b2 = '1;
    repeat (3) @(posedge clk); #1;
    chk("R1", 41'd0, '1);
    @(negedge clk); rst = 1'b0;
    // fixed corner configurations
    apply('0, '0, '0, '0);
    apply('1, '1, '1, '0);
    apply('1, '1, '1, '1);
    apply(32'hFFFF_C000, 32'h0, 32'h0, 32'h0);
    apply(32'h0, 32'hFF00_0000, 32'h0, 32'h0);
    apply(32'h0, 32'h00FC_0000, 32'h0, 32'hFFFF_FFFF);
    // walk one line per bank with its routing bit both ways
    for (int n = 0; n < 32; n++) begin
      apply(32'd1 << n, '0, '0, '0);
      apply(32'd1 << n, '0, '0, 32'd1 << n);
      apply('0, 32'd1 << n, '0, '0);
      apply('0, 32'd1 << n, '0, '1);
      apply('0, '0, 32'd1 << n, '0);
      apply('0, '0, 32'd1 << n, 32'd1 << n);
    end
    // random sweeps under all-zero, all-one and random routing
    for (int k = 0; k < 300; k++) begin
      apply($urandom, $urandom, $urandom, '0);
      apply($urandom, $urandom, $urandom, '1);
      apply($urandom, $urandom, $urandom, $urandom);
    end
    // R9: change between edges leaves outputs held
    apply(32'h0000_1234, 32'h00AB_0000, 32'h5, 32'h3);
    held = q;
    @(negedge clk);
    b0 = ~b0; b1 = ~b1; b2 = ~b2; cfg = ~cfg;
    #2;
    chk("R9", held, '1);
    @(posedge clk); #1;
    chk("R9", model(b0, b1, b2, cfg), '1);
    // R1: reset in mid-run clears outputs
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R1", 41'd0, '1);
    finish_run();
  end
endmodule